// File: doc/BRIEF.md
# SIMD Floating-Point Compare Mask Generator

This block compares two 128-bit vectors lane by lane as IEEE-754 single-precision (four 32-bit lanes) or double-precision (two 64-bit lanes) values. For each lane, a three-bit predicate selects the test. The lane result is a mask of the lane width, either all ones (true) or all zeros (false). When either operand of a lane is a NaN, the pair is unordered. In that case the predicate fixes the mask value and also decides whether the lane signals an invalid-operation condition.

Scalar mode computes only the lowest lane. The upper part of the result is copied from operand A. An invalid-mask input chooses how an invalid lane is handled. When the exception is masked, the default mask is written. When it is unmasked, the writeback of the whole operation is suppressed and a fault is reported. Per-lane invalid flags are also ORed into a sticky status bit. The result is registered one cycle after the operation is accepted.

Top module: `simd_cmp_mask`

## Requirements
- R1: Predicate code 0 (EQ) and code 7 (ORD) give an all-zeros lane mask when either operand is a NaN (exponent all ones, fraction non-zero) and flag no invalid.
- R2: Predicate code 4 (NEQ) and code 3 (UNORD) give an all-ones lane mask when either operand is a NaN and flag no invalid.
- R3: Predicate code 1 (LT) and code 2 (LE) give an all-zeros mask when either operand is a NaN and set that lane's invalid flag.
- R4: Predicate code 5 (NLT) and code 6 (NLE) give an all-ones mask when either operand is a NaN and set that lane's invalid flag.
- R5: With `in_dbl`=0, lane i occupies bits [32i+31:32i] and its invalid flag is bit i. With `in_dbl`=1, lane j occupies bits [64j+63:64j], its flag is bit j, and flag bits 2 and 3 read 0.
- R6: For ordered operands, +0 and -0 compare equal. Ordering follows the signed value, including for negative numbers and infinities.
- R7: For ordered operands, codes 4, 5 and 6 give the complement of codes 0, 1 and 2, and ORD (code 7) is true.
- R8: With `in_packed`=0, only the lowest lane is compared. All higher result bits equal operand A, and the higher lanes raise no invalid flag.
- R9: When any active lane flags invalid and `in_mask_inv`=0, the following hold on the output cycle: `out_fault`=1, `out_wb_en`=0, and `out_result` keeps its previous value.
- R10: `inv_sticky` becomes 1 after any operation with a lane invalid flag, whether the exception is masked or not. Only reset clears it.
- R11: Outputs appear one clock after `in_valid`. Reset clears result, flags, valid, writeback enable and sticky bit to zero. `out_wb_en`=1 exactly for valid, non-faulting operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_pred | input | 3 | Predicate code (0 EQ,1 LT,2 LE,3 UNORD,4 NEQ,5 NLT,6 NLE,7 ORD) |
| in_dbl | input | 1 | 1 selects double-precision lanes |
| in_packed | input | 1 | 1 compares all lanes, 0 only the lowest |
| in_mask_inv | input | 1 | 1 masks the invalid exception |
| opa | input | VEC_W | Operand A |
| opb | input | VEC_W | Operand B |
| out_valid | output | 1 | Result cycle of an accepted operation |
| out_wb_en | output | 1 | Result may be written back |
| out_fault | output | 1 | Unmasked invalid exception raised |
| out_result | output | VEC_W | Mask vector |
| out_lane_inv | output | VEC_W/32 | Per-lane invalid flags |
| inv_sticky | output | 1 | Sticky invalid status |

## Verification
The hardest case is a packed double operation in which one lane is an unordered pair under an ordered-class predicate while the other lane is ordinary. With exceptions unmasked, that single lane must suppress writeback of the whole vector and freeze the previous result. Uniform random bits almost never form NaNs, so the stimulus draws each lane from a weighted pool of NaNs, signed zeros, infinities and equal pairs. Directed cases then place a single NaN in a chosen lane under each predicate and each mask setting.

// File: rtl/simd_cmp_pkg.sv
// Package: shared predicate codes and lane geometry for the compare mask block.
// Assumes a vector width that is a multiple of 64 bits.
package simd_cmp_pkg;
    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NEQ   = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } cmp_pred_e;

    localparam int SP_W   = 32;
    localparam int DP_W   = 64;
    localparam int SP_EXP = 8;
    localparam int DP_EXP = 11;
endpackage

// File: rtl/fp_lane_cmp.sv
// Module: fp_lane_cmp
// Compares two IEEE-754 values of one lane. It reports unordered (either
// operand NaN), equal and less-than. eq and lt are forced low when unordered.
// Assumes a standard sign/exponent/fraction layout with an EXP_W-bit exponent.
module fp_lane_cmp #(
    parameter int W     = 32,
    parameter int EXP_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         unord,
    output logic         eq,
    output logic         lt
);
    localparam int MAN_W = W - 1 - EXP_W;

    logic         a_nan, b_nan, both_zero;
    logic [W-2:0] a_mag, b_mag;
    logic         a_s, b_s;

    // Field split and NaN detection.
    always_comb begin
        a_s   = a[W-1];
        b_s   = b[W-1];
        a_mag = a[W-2:0];
        b_mag = b[W-2:0];
        a_nan = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
        b_nan = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
        both_zero = (a_mag == '0) && (b_mag == '0);
    end

    // Sign-magnitude ordering with signed zeros treated as equal.
    always_comb begin
        unord = a_nan || b_nan;
        eq    = 1'b0;
        lt    = 1'b0;
        if (!unord) begin
            eq = both_zero || (a == b);
            if (!eq) begin
                if (a_s != b_s)  lt = a_s;
                else if (!a_s)   lt = a_mag < b_mag;
                else             lt = a_mag > b_mag;
            end
        end
    end

    // Relation outputs are mutually exclusive.
    always_comb begin
        assert (!(eq && lt) && !(unord && (eq || lt)))
            else $error("AST_REL_EXCL violated"); // R6
    end
endmodule

// File: rtl/pred_apply.sv
// Module: pred_apply
// Turns a lane relation into the lane mask bit and its invalid flag for the
// selected predicate. Bit 2 of the code complements the base test. Base codes
// 1 and 2 are the ordered-class tests that signal on unordered input.
module pred_apply
    import simd_cmp_pkg::*;
(
    input  logic [2:0] pred,
    input  logic       unord,
    input  logic       eq,
    input  logic       lt,
    output logic       mask_bit,
    output logic       inv
);
    logic base_res;
    logic signal_cls;

    // Base relation select, then complement for codes 4..7.
    always_comb begin
        unique case (pred[1:0])
            2'd0:    base_res = eq;
            2'd1:    base_res = lt;
            2'd2:    base_res = lt || eq;
            default: base_res = unord;
        endcase
        mask_bit   = base_res ^ pred[2];
        signal_cls = (pred[1:0] == 2'd1) || (pred[1:0] == 2'd2);
        inv        = unord && signal_cls;
    end

    // Unordered lanes follow the fixed table.
    always_comb begin
        if (unord && (pred == PR_EQ || pred == PR_ORD))
            assert (!mask_bit && !inv) else $error("AST_QUIET_ZERO violated"); // R1
        if (unord && (pred == PR_NEQ || pred == PR_UNORD))
            assert (mask_bit && !inv) else $error("AST_QUIET_ONES violated"); // R2
    end
endmodule

// File: rtl/simd_cmp_mask.sv
// Module: simd_cmp_mask (top)
// Packed or scalar SIMD compare. It builds per-lane masks for single or
// double precision, flags invalid lanes, suppresses writeback on an unmasked
// invalid and keeps a sticky invalid bit. Registered, one cycle latency.
// Assumes VEC_W is a multiple of 64.
module simd_cmp_mask
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            in_pred,
    input  logic                  in_dbl,
    input  logic                  in_packed,
    input  logic                  in_mask_inv,
    input  logic [VEC_W-1:0]      opa,
    input  logic [VEC_W-1:0]      opb,
    output logic                  out_valid,
    output logic                  out_wb_en,
    output logic                  out_fault,
    output logic [VEC_W-1:0]      out_result,
    output logic [VEC_W/32-1:0]   out_lane_inv,
    output logic                  inv_sticky
);
    localparam int SPL = VEC_W / SP_W;
    localparam int DPL = VEC_W / DP_W;

    logic [SPL-1:0]   sp_m, sp_i, sp_u, sp_e, sp_l;
    logic [DPL-1:0]   dp_m, dp_i, dp_u, dp_e, dp_l;
    logic [VEC_W-1:0] sp_res, dp_res, nxt_res;
    logic [SPL-1:0]   nxt_inv;
    logic             nxt_fault;

    genvar gi;
    generate
        for (gi = 0; gi < SPL; gi++) begin : g_sp
            fp_lane_cmp #(.W(SP_W), .EXP_W(SP_EXP)) u_cmp (
                .a(opa[gi*SP_W +: SP_W]), .b(opb[gi*SP_W +: SP_W]),
                .unord(sp_u[gi]), .eq(sp_e[gi]), .lt(sp_l[gi]));
            pred_apply u_pred (
                .pred(in_pred), .unord(sp_u[gi]), .eq(sp_e[gi]), .lt(sp_l[gi]),
                .mask_bit(sp_m[gi]), .inv(sp_i[gi]));
            // Active lanes take the mask; inactive lanes pass operand A.
            always_comb begin
                sp_res[gi*SP_W +: SP_W] = (in_packed || gi == 0) ?
                    {SP_W{sp_m[gi]}} : opa[gi*SP_W +: SP_W];
            end
        end
        for (gi = 0; gi < DPL; gi++) begin : g_dp
            fp_lane_cmp #(.W(DP_W), .EXP_W(DP_EXP)) u_cmp (
                .a(opa[gi*DP_W +: DP_W]), .b(opb[gi*DP_W +: DP_W]),
                .unord(dp_u[gi]), .eq(dp_e[gi]), .lt(dp_l[gi]));
            pred_apply u_pred (
                .pred(in_pred), .unord(dp_u[gi]), .eq(dp_e[gi]), .lt(dp_l[gi]),
                .mask_bit(dp_m[gi]), .inv(dp_i[gi]));
            // Active lanes take the mask; inactive lanes pass operand A.
            always_comb begin
                dp_res[gi*DP_W +: DP_W] = (in_packed || gi == 0) ?
                    {DP_W{dp_m[gi]}} : opa[gi*DP_W +: DP_W];
            end
        end
    endgenerate

    // Precision select for result and per-lane invalid flags.
    always_comb begin
        nxt_res = in_dbl ? dp_res : sp_res;
        for (int i = 0; i < SPL; i++) begin
            if (in_dbl)
                nxt_inv[i] = (i < DPL) ? (dp_i[i % DPL] && (in_packed || i == 0)) : 1'b0;
            else
                nxt_inv[i] = sp_i[i] && (in_packed || i == 0);
        end
        nxt_fault = (|nxt_inv) && !in_mask_inv;
    end

    // Output registers with writeback suppression on unmasked invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_wb_en    <= 1'b0;
            out_fault    <= 1'b0;
            out_result   <= '0;
            out_lane_inv <= '0;
        end else begin
            out_valid    <= in_valid;
            out_wb_en    <= in_valid && !nxt_fault;
            out_fault    <= in_valid && nxt_fault;
            out_lane_inv <= in_valid ? nxt_inv : '0;
            if (in_valid && !nxt_fault)
                out_result <= nxt_res;
        end
    end

    // Sticky invalid status, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    inv_sticky <= 1'b0;
        else if (in_valid && |nxt_inv) inv_sticky <= 1'b1;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        inv_sticky |=> inv_sticky); // R10
    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> !out_wb_en); // R9
    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_result == $past(out_result)); // R9
    AST_FAULT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (|out_lane_inv && inv_sticky)); // R10
    AST_WB_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_en |-> out_valid); // R11
endmodule

// File: tb/tb_simd_cmp_mask.sv
module tb_simd_cmp_mask;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_valid = 0;
    logic [2:0]   in_pred = 0;
    logic         in_dbl = 0, in_packed = 0, in_mask_inv = 1;
    logic [127:0] opa = 0, opb = 0;
    logic         out_valid, out_wb_en, out_fault, inv_sticky;
    logic [127:0] out_result;
    logic [3:0]   out_lane_inv;

    int checks = 0, errors = 0;
    logic [127:0] exp_prev = 0;
    bit           exp_sticky = 0;

    always #2 clk = ~clk;

    simd_cmp_mask dut (.*);

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(string req, logic [127:0] act, logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Reference lane evaluation written from the requirements.
    function automatic void lane_ref(input logic [63:0] a, input logic [63:0] b,
                                     input bit dp, input logic [2:0] p,
                                     output bit m, output bit inv);
        bit an, bn, sa, sb, eq, lt, r;
        logic [62:0] ma, mb;
        if (dp) begin
            an = (a[62:52] == 11'h7ff) && (a[51:0] != 0);
            bn = (b[62:52] == 11'h7ff) && (b[51:0] != 0);
            sa = a[63]; sb = b[63]; ma = a[62:0]; mb = b[62:0];
        end else begin
            an = (a[30:23] == 8'hff) && (a[22:0] != 0);
            bn = (b[30:23] == 8'hff) && (b[22:0] != 0);
            sa = a[31]; sb = b[31]; ma = {32'h0, a[30:0]}; mb = {32'h0, b[30:0]};
        end
        eq = 0; lt = 0;
        if (an || bn) begin
            m   = (p == 3 || p == 4 || p == 5 || p == 6);
            inv = (p == 1 || p == 2 || p == 5 || p == 6);
            return;
        end
        if ((ma == 0 && mb == 0) || (sa == sb && ma == mb)) eq = 1;
        else if (sa != sb) lt = sa;
        else lt = sa ? (ma > mb) : (ma < mb);
        case (p)
            0: r = eq; 1: r = lt; 2: r = lt | eq; 3: r = 0;
            4: r = !eq; 5: r = !lt; 6: r = !(lt | eq); default: r = 1;
        endcase
        m = r; inv = 0;
    endfunction

    task automatic run_op(string req, logic [2:0] p, bit dp, bit pk, bit mk,
                          logic [127:0] a, logic [127:0] b);
        logic [127:0] er; logic [3:0] ei; bit m, iv, flt;
        er = a; ei = 0;
        if (dp) begin
            for (int j = 0; j < 2; j++) if (pk || j == 0) begin
                lane_ref(a[j*64 +: 64], b[j*64 +: 64], 1, p, m, iv);
                er[j*64 +: 64] = {64{m}}; ei[j] = iv;
            end
        end else begin
            for (int i = 0; i < 4; i++) if (pk || i == 0) begin
                lane_ref({32'h0, a[i*32 +: 32]}, {32'h0, b[i*32 +: 32]}, 0, p, m, iv);
                er[i*32 +: 32] = {32{m}}; ei[i] = iv;
            end
        end
        flt = (ei != 0) && !mk;
        if (!flt) exp_prev = er;
        if (ei != 0) exp_sticky = 1;
        @(negedge clk);
        in_valid = 1; in_pred = p; in_dbl = dp; in_packed = pk; in_mask_inv = mk;
        opa = a; opb = b;
        @(negedge clk);
        in_valid = 0;
        chk({req, " result"}, out_result, exp_prev);
        chk({req, " lane_inv R5"}, {124'h0, out_lane_inv}, {124'h0, ei});
        chk({req, " fault R9"}, {127'h0, out_fault}, {127'h0, flt});
        chk({req, " wb_en R11"}, {127'h0, out_wb_en}, {127'h0, !flt});
        chk({req, " sticky R10"}, {127'h0, inv_sticky}, {127'h0, exp_sticky});
    endtask

    function automatic logic [31:0] gen32();
        case ($urandom % 8)
            0: return {$urandom % 2 == 1, 8'hff, 1'b1, 22'($urandom)};
            1: return {$urandom % 2 == 1, 8'hff, 1'b0, 22'($urandom | 1)};
            2: return {$urandom % 2 == 1, 31'h0};
            3: return {$urandom % 2 == 1, 8'hff, 23'h0};
            4: return 32'h3f800000;
            default: return {$urandom % 2 == 1, 8'($urandom % 255), 23'($urandom)};
        endcase
    endfunction

    function automatic logic [63:0] gen64();
        case ($urandom % 8)
            0: return {$urandom % 2 == 1, 11'h7ff, 1'b1, 51'($urandom)};
            1: return {$urandom % 2 == 1, 11'h7ff, 1'b0, 51'($urandom | 1)};
            2: return {$urandom % 2 == 1, 63'h0};
            3: return {$urandom % 2 == 1, 11'h7ff, 52'h0};
            4: return 64'h3ff0000000000000;
            default: return {$urandom % 2 == 1, 11'($urandom % 2047), 20'($urandom), 32'($urandom)};
        endcase
    endfunction

    localparam logic [31:0] SNAN = 32'h7f800001, QNAN = 32'h7fc00000;
    localparam logic [63:0] DNAN = 64'h7ff8000000000000;

    initial begin
        logic [127:0] a, b;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        chk("R11 reset result", out_result, 0);
        chk("R11 reset flags", {123'h0, out_valid, out_wb_en, out_fault, inv_sticky, 1'b0},
            128'h0);
        rst_n = 1;
        // R1 / R2: NaN under quiet predicates, sticky must stay clear (R10).
        run_op("R1 EQ nan", 0, 0, 1, 1, {4{QNAN}}, {4{32'h1}});
        run_op("R1 ORD nan", 7, 0, 1, 0, {96'h0, SNAN}, 0);
        run_op("R2 NEQ nan", 4, 1, 1, 0, {DNAN, 64'h0}, 0);
        run_op("R2 UNORD nan", 3, 0, 1, 0, 0, {4{SNAN}});
        // R6: signed zeros and negative ordering.
        run_op("R6 zeros", 0, 0, 1, 1, {32'h80000000, 32'h0, 32'hbf800000, 32'hff800000},
               {32'h0, 32'h80000000, 32'hc0000000, 32'hbf800000});
        run_op("R6 lt neg", 1, 1, 1, 1, {64'hc000000000000000, 64'h8000000000000000},
               {64'hbff0000000000000, 64'h0});
        // R7: complements.
        run_op("R7 NLE", 6, 0, 1, 1, {32'h1, 32'h2, 32'h80000001, 32'h0},
               {32'h2, 32'h1, 32'h0, 32'h0});
        // R8: scalar keeps upper bits of A.
        run_op("R8 scalar", 1, 0, 0, 1, {96'hdeadbeef_01234567_89abcdef, 32'h0},
               {{3{SNAN}}, 32'h3f800000});
        // R3 / R4 masked then unmasked (R9).
        run_op("R3 LT masked", 1, 1, 1, 1, {64'h0, DNAN}, 0);
        run_op("R4 NLT masked", 5, 0, 1, 1, {32'h0, QNAN, 64'h0}, 0);
        run_op("R9 LE unmasked", 2, 1, 1, 0, {DNAN, 64'h0}, 0);
        run_op("R9 NLE unmasked", 6, 0, 1, 0, {QNAN, 96'h0}, 0);
        for (int n = 0; n < 400; n++) begin
            bit dp;
            dp = $urandom % 2 == 1;
            for (int k = 0; k < 4; k++) begin
                if (dp && k < 2) begin
                    a[k*64 +: 64] = gen64(); b[k*64 +: 64] = ($urandom % 4 == 0) ? a[k*64 +: 64] : gen64();
                end else if (!dp) begin
                    a[k*32 +: 32] = gen32(); b[k*32 +: 32] = ($urandom % 4 == 0) ? a[k*32 +: 32] : gen32();
                end
            end
            run_op("R5 random", 3'($urandom), dp, $urandom % 3 != 0, $urandom % 2 == 1, a, b);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule